// File: doc/BRIEF.md
# Zero-Substitution Line Code Encoder

This block turns dual-rail unipolar transmit data into a pair of bipolar line rails (a positive rail and a negative rail) using alternate mark inversion with zero substitution. A mode input chooses between three-zero substitution (B3ZS) and four-zero substitution (HDB3). In both modes a long run of zeros is replaced by a code that carries a deliberate bipolar violation (V), sometimes preceded by a balancing pulse (B) that does obey the alternation rule. The choice between the two codes depends on how many marks have been sent since the previous violation, so that the number of B-type marks between two violations is always odd.

Three controls can take over the line. An encoder-disable input lets already-encoded rails through unchanged. An all-ones request forces a continuous alternating mark pattern, and it also overrides the encoder-disable input. A remote-loopback request sends the receive-side rails to the line and ignores the all-ones request. Transmit and receive rails are sampled on the falling edge of the bit clock. The integrating logic is expected to present the receive rails already retimed to that same clock. When the mode input changes, the substitution state is flushed, so no half-built code from the old mode ever reaches the line.

Top module: `zcs_line_encoder`

## Requirements
- R1: After reset the line rails are both low, and the encoder state is "last mark positive, even mark count". The first encoded mark after reset therefore goes out on the negative rail.
- R2: A bit is a mark when either transmit rail is high at the sampling falling edge, so driving both rails with the same binary signal encodes correctly. In encoder mode, successive ordinary marks alternate between the rails.
- R3: With `b3zs_sel`=1, every run of three zeros is replaced. The code is B0V when the count of marks since the last V is even, and 00V when it is odd. V takes the same polarity as the mark before it, and B takes the opposite polarity.
- R4: With `b3zs_sel`=0, every run of four zeros is replaced. The code is B00V when the count is even and 000V when it is odd, under the same polarity rules. Runs of three zeros stay zeros.
- R5: In encoder mode, the rails for a bit change on the fifth rising edge after its sampling falling edge with B3ZS (4.5 cycles), and on the sixth with HDB3 (5.5 cycles).
- R6: With `enc_dis`=1 and neither override active, the transmit rails are copied to the line on the second rising edge after sampling (1.5 cycles). A bit period with both input rails high leaves the line idle.
- R7: With `aos`=1 and `rloop`=0, each bit period drives exactly one rail, and the rails alternate. This holds whatever the value of `enc_dis`. After reset the first all-ones mark is on the negative rail.
- R8: With `rloop`=1, the receive rails reach the line with the R6 timing and the same idle rule. The transmit rails and `aos` have no effect.
- R9: `line_p` and `line_n` are never high in the same bit period.
- R10: A change of `b3zs_sel` clears the zero-run, parity and polarity state and the symbols waiting in the window. Encoding then restarts exactly as it does after reset, beginning with the bit sampled after the changed mode is first seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; rails sampled on falling edge, state on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| b3zs_sel | input | 1 | 1 selects three-zero substitution, 0 selects four-zero |
| enc_dis | input | 1 | Pass transmit rails through without substitution |
| aos | input | 1 | Force continuous alternating marks |
| rloop | input | 1 | Send receive rails to the line |
| tx_p | input | 1 | Transmit positive rail / unipolar data |
| tx_n | input | 1 | Transmit negative rail / unipolar data |
| rx_p | input | 1 | Receive positive rail for loopback |
| rx_n | input | 1 | Receive negative rail for loopback |
| line_p | output | 1 | Positive line rail |
| line_n | output | 1 | Negative line rail |

## Verification
The checker watches four things on every cycle. The two line rails must never be high together, and reset must leave them idle. Under a steady all-ones request the rails must swap every cycle. When the pass-through or loopback paths are selected, the line must follow its source stage exactly one edge later. Whether the substitution codes are right cannot be expressed as a simple property, because the B0V/00V choice depends on mark parity, V must repeat the previous polarity, and the latency differs by mode. Those rules, and the restart after a mode change, are shown only by the bench scenarios: random and sparse streams, all-zero runs, and runs exactly one zero short of a substitution, each compared against a bench model of the coding rules.

// File: rtl/zcs_pkg.sv
package zcs_pkg;
  // Symbol kinds held in the substitution window.
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_BPOL = 2'd2,
    SYM_VIOL = 2'd3
  } sym_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/zcs_rail_capture.sv
// Falling-edge capture of every rail lane, followed by one rising-edge stage.
// Lanes 0 and 1 carry the transmit rails; their captured OR is the mark bit.
module zcs_rail_capture #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_in,
  output logic             tx_mark,
  output logic [LANES-1:0] lane_rise
);
  logic [LANES-1:0] lane_fall;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      always_ff @(negedge clk) begin
        if (rst) lane_fall[g] <= 1'b0;
        else     lane_fall[g] <= lane_in[g];
      end
      always_ff @(posedge clk) begin
        if (rst) lane_rise[g] <= 1'b0;
        else     lane_rise[g] <= lane_fall[g];
      end
    end
  endgenerate

  assign tx_mark = lane_fall[0] | lane_fall[1];
endmodule

// File: rtl/zcs_substitute.sv
// Zero-run detection and code insertion. The decision is taken at the tail of
// the window as each bit enters; a balancing pulse is written back into the
// oldest zero of the run. The head tap moves with the selected run length.
module zcs_substitute
  import zcs_pkg::*;
#(
  parameter int RUN_SHORT = 3,
  parameter int RUN_LONG  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic long_mode,
  input  logic in_mark,
  output sym_t head
);
  localparam int WIN = max_of(RUN_SHORT, RUN_LONG);
  localparam int CW  = $clog2(WIN + 1);
  localparam int IW  = (WIN > 1) ? $clog2(WIN) : 1;

  sym_t [WIN-1:0] win;
  logic [CW-1:0]  zrun;
  logic           par_odd;
  logic [CW-1:0]  run_m1;
  logic [IW-1:0]  tap_idx;

  assign run_m1  = long_mode ? CW'(RUN_LONG - 1) : CW'(RUN_SHORT - 1);
  assign tap_idx = run_m1[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < WIN; i++) win[i] <= SYM_ZERO;
      zrun    <= '0;
      par_odd <= 1'b0;
    end else begin
      for (int i = 1; i < WIN; i++) win[i] <= win[i-1];
      if (in_mark) begin
        win[0]  <= SYM_MARK;
        par_odd <= ~par_odd;
        zrun    <= '0;
      end else if (zrun == run_m1) begin
        win[0]  <= SYM_VIOL;
        zrun    <= '0;
        par_odd <= 1'b0;
        if (!par_odd) win[tap_idx] <= SYM_BPOL;
      end else begin
        win[0] <= SYM_ZERO;
        zrun   <= zrun + 1'b1;
      end
    end
  end

  assign head = win[tap_idx];
endmodule

// File: rtl/zcs_polarity.sv
// Assigns a rail to each symbol leaving the window.
module zcs_polarity
  import zcs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  sym_t head,
  output logic enc_p,
  output logic enc_n
);
  logic last_pos;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      enc_p    <= 1'b0;
      enc_n    <= 1'b0;
      last_pos <= 1'b1;
    end else begin
      case (head)
        SYM_MARK, SYM_BPOL: begin
          enc_p    <= ~last_pos;
          enc_n    <= last_pos;
          last_pos <= ~last_pos;
        end
        SYM_VIOL: begin
          enc_p <= last_pos;
          enc_n <= ~last_pos;
        end
        default: begin
          enc_p <= 1'b0;
          enc_n <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/zcs_line_mux.sv
// Output register with override priority: loopback, all-ones, bypass, encoder.
module zcs_line_mux (
  input  logic clk,
  input  logic rst,
  input  logic rloop,
  input  logic aos,
  input  logic enc_dis,
  input  logic lb_p,
  input  logic lb_n,
  input  logic byp_p,
  input  logic byp_n,
  input  logic enc_p,
  input  logic enc_n,
  output logic line_p,
  output logic line_n
);
  logic aos_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_p  <= 1'b0;
      line_n  <= 1'b0;
      aos_pos <= 1'b1;
    end else if (rloop) begin
      line_p <= lb_p & ~lb_n;
      line_n <= lb_n & ~lb_p;
    end else if (aos) begin
      line_p  <= ~aos_pos;
      line_n  <= aos_pos;
      aos_pos <= ~aos_pos;
    end else if (enc_dis) begin
      line_p <= byp_p & ~byp_n;
      line_n <= byp_n & ~byp_p;
    end else begin
      line_p <= enc_p;
      line_n <= enc_n;
    end
  end
endmodule

// File: rtl/zcs_line_encoder.sv
module zcs_line_encoder
  import zcs_pkg::*;
#(
  parameter int RUN_SHORT = 3,
  parameter int RUN_LONG  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic b3zs_sel,
  input  logic enc_dis,
  input  logic aos,
  input  logic rloop,
  input  logic tx_p,
  input  logic tx_n,
  input  logic rx_p,
  input  logic rx_n,
  output logic line_p,
  output logic line_n
);
  localparam int LANES = 4;

  logic [LANES-1:0] lane_rise;
  logic             tx_mark;
  logic             mode_q;
  logic             flush;
  logic             byp_p, byp_n, lb_p, lb_n;
  logic             enc_p, enc_n;
  sym_t             head;

  always_ff @(posedge clk) begin
    mode_q <= b3zs_sel;
  end
  assign flush = ~rst & (b3zs_sel != mode_q);

  zcs_rail_capture #(.LANES(LANES)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .lane_in   ({rx_n, rx_p, tx_n, tx_p}),
    .tx_mark   (tx_mark),
    .lane_rise (lane_rise)
  );

  assign byp_p = lane_rise[0];
  assign byp_n = lane_rise[1];
  assign lb_p  = lane_rise[2];
  assign lb_n  = lane_rise[3];

  zcs_substitute #(.RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG)) u_sub (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .long_mode (~b3zs_sel),
    .in_mark   (tx_mark),
    .head      (head)
  );

  zcs_polarity u_pol (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .head  (head),
    .enc_p (enc_p),
    .enc_n (enc_n)
  );

  zcs_line_mux u_mux (
    .clk     (clk),
    .rst     (rst),
    .rloop   (rloop),
    .aos     (aos),
    .enc_dis (enc_dis),
    .lb_p    (lb_p),
    .lb_n    (lb_n),
    .byp_p   (byp_p),
    .byp_n   (byp_n),
    .enc_p   (enc_p),
    .enc_n   (enc_n),
    .line_p  (line_p),
    .line_n  (line_n)
  );
endmodule

// File: rtl/zcs_line_encoder_chk.sv
module zcs_line_encoder_chk (
  input logic clk,
  input logic rst,
  input logic aos,
  input logic rloop,
  input logic enc_dis,
  input logic byp_p,
  input logic byp_n,
  input logic lb_p,
  input logic lb_n,
  input logic line_p,
  input logic line_n
);
  // R1: reset leaves the line idle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!line_p && !line_n));

  // R9: rails exclusive
  p_rails_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(line_p && line_n));

  // R7: steady all-ones request swaps the rails every cycle
  p_aos_alt_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(aos && !rloop) && $past(aos && !rloop, 2) && !$past(rst) && !$past(rst, 2))
    |-> ((line_p != line_n) && (line_p == $past(line_n))));

  // R6: bypass copies the retimed transmit stage
  p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(enc_dis && !aos && !rloop) && !$past(rst))
    |-> ((line_p == $past(byp_p && !byp_n)) && (line_n == $past(byp_n && !byp_p))));

  // R8: loopback copies the retimed receive stage
  p_loop_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(rloop) && !$past(rst))
    |-> ((line_p == $past(lb_p && !lb_n)) && (line_n == $past(lb_n && !lb_p))));
endmodule

bind zcs_line_encoder zcs_line_encoder_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .aos     (aos),
  .rloop   (rloop),
  .enc_dis (enc_dis),
  .byp_p   (byp_p),
  .byp_n   (byp_n),
  .lb_p    (lb_p),
  .lb_n    (lb_n),
  .line_p  (line_p),
  .line_n  (line_n)
);

// File: tb/zcs_line_encoder_test.sv
module zcs_line_encoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic b3zs_sel = 1'b1, enc_dis = 1'b0, aos = 1'b0, rloop = 1'b0;
  logic tx_p = 1'b0, tx_n = 1'b0, rx_p = 1'b0, rx_n = 1'b0;
  logic line_p, line_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  int unsigned seed_v;

  bit sb[1024];
  bit sp[1024];
  bit sn[1024];
  bit ep[1024];
  bit en[1024];
  int kd[1024];

  always #10 clk = ~clk;  // 50 MHz

  zcs_line_encoder uut (
    .clk(clk), .rst(rst), .b3zs_sel(b3zs_sel), .enc_dis(enc_dis),
    .aos(aos), .rloop(rloop), .tx_p(tx_p), .tx_n(tx_n),
    .rx_p(rx_p), .rx_n(rx_n), .line_p(line_p), .line_n(line_n)
  );

  task automatic chk(input string req, input int c, input bit gp, input bit gn,
                     input bit xp, input bit xn);
    n_checks++;
    if (gp !== xp || gn !== xn) begin
      n_fail++;
      $display("FAIL %s cycle=%0d actual p=%0b n=%0b expected p=%0b n=%0b",
               req, c, gp, gn, xp, xn);
    end
    n_checks++;
    if (gp && gn) begin
      n_fail++;
      $display("FAIL R9 cycle=%0d actual p=1 n=1 expected not both", c);
    end
  endtask

  // Reference coding rules (R3/R4) followed by polarity assignment (R1/R2).
  task automatic build_enc(input bit b3, input int n);
    int run = b3 ? 3 : 4;
    int zc = 0;
    bit par = 0;
    bit last = 1;
    for (int j = 0; j < n; j++) begin
      kd[j] = 0;
      if (sb[j]) begin
        kd[j] = 1; par = ~par; zc = 0;
      end else if (zc == run - 1) begin
        kd[j] = 3;
        if (!par) kd[j-run+1] = 2;
        par = 0; zc = 0;
      end else zc++;
    end
    for (int j = 0; j < n; j++) begin
      ep[j] = 0; en[j] = 0;
      if (kd[j] == 1 || kd[j] == 2) begin
        last = ~last; ep[j] = last; en[j] = ~last;
      end else if (kd[j] == 3) begin
        ep[j] = last; en[j] = ~last;
      end
    end
  endtask

  // kind: 0 encoder, 1 bypass, 2 all-ones, 3 loopback
  // pat: 0 dense, 1 sparse, 2 zeros, 3 preset; rm: 0 p only, 1 tied, 2 random rail
  task automatic run_seg(input string req, input bit do_rst, input bit b3,
                         input int kind, input int n, input int pat, input int rm);
    int lat;
    bit dis;
    for (int j = 0; j < n + 8; j++) begin
      if (j >= n) begin
        sb[j] = 0;
      end else begin
        case (pat)
          0: sb[j] = bit'($urandom % 2);
          1: sb[j] = ($urandom % 5) == 0;
          2: sb[j] = 0;
          default: ;
        endcase
      end
      if (kind == 1 || kind == 3) begin
        sp[j] = (j < n) ? bit'($urandom % 2) : 1'b0;
        sn[j] = (j < n) ? bit'($urandom % 2) : 1'b0;
      end else begin
        bit r = bit'($urandom % 2);
        case (rm)
          0: begin sp[j] = sb[j]; sn[j] = 0; end
          1: begin sp[j] = sb[j]; sn[j] = sb[j]; end
          default: begin sp[j] = sb[j] & r; sn[j] = sb[j] & ~r; end
        endcase
      end
    end
    case (kind)
      0: begin build_enc(b3, n + 8); lat = b3 ? 5 : 6; end
      2: begin
        for (int j = 0; j < n + 8; j++) begin ep[j] = j[0]; en[j] = ~j[0]; end
        lat = 1;
      end
      default: begin
        for (int j = 0; j < n + 8; j++) begin ep[j] = sp[j] & ~sn[j]; en[j] = sn[j] & ~sp[j]; end
        lat = 2;
      end
    endcase
    dis = (kind == 1) || (kind >= 2 && ($urandom % 2) == 1);
    @(posedge clk); #1;
    if (do_rst) rst = 1'b1;
    b3zs_sel = b3; enc_dis = dis; aos = (kind >= 2); rloop = (kind == 3);
    tx_p = 0; tx_n = 0; rx_p = 0; rx_n = 0;
    for (int c = 0; c < n + lat; c++) begin
      @(posedge clk); #1;
      if (c == 0) rst = 1'b0;
      if (kind == 3) begin
        rx_p = sp[c]; rx_n = sn[c];
        tx_p = bit'($urandom % 2); tx_n = bit'($urandom % 2);
      end else begin
        tx_p = sp[c]; tx_n = sn[c];
        rx_p = bit'($urandom % 2); rx_n = bit'($urandom % 2);
      end
      #4;
      if (do_rst && c == 0) chk("R1 reset idle", c, line_p, line_n, 1'b0, 1'b0);
      if (c >= lat) chk(req, c, line_p, line_n, ep[c-lat], en[c-lat]);
    end
  endtask

  initial begin
    seed_v = $urandom(32'd20511);
    repeat (3) @(posedge clk);

    // R1: first mark after reset negative; trailing zeros substituted
    for (int j = 0; j < 12; j++) sb[j] = (j == 0);
    run_seg("R1 first mark negative", 1, 1, 0, 12, 3, 0);
    // R3/R5: three-zero substitution boundaries
    begin
      bit pat3[12] = '{1,1,0,0,1,0,0,0,0,0,0,1};
      for (int j = 0; j < 12; j++) sb[j] = pat3[j];
    end
    run_seg("R3 directed runs", 1, 1, 0, 12, 3, 0);
    run_seg("R3/R5 dense", 1, 1, 0, 200, 0, 2);
    run_seg("R3/R5 sparse", 1, 1, 0, 200, 1, 0);
    // R4: four-zero substitution, three-zero run untouched
    begin
      bit pat4[15] = '{1,0,0,0,1,0,0,0,0,1,1,0,0,0,0};
      for (int j = 0; j < 15; j++) sb[j] = pat4[j];
    end
    run_seg("R4 directed runs", 1, 0, 0, 15, 3, 0);
    run_seg("R4/R5 dense", 1, 0, 0, 200, 0, 2);
    run_seg("R4 all zeros", 1, 0, 0, 40, 2, 0);
    run_seg("R3 all zeros", 1, 1, 0, 40, 2, 0);
    // R2: tied rails as binary input
    run_seg("R2 tied rails", 1, 1, 0, 150, 0, 1);
    run_seg("R2 tied rails hdb3", 1, 0, 0, 150, 1, 1);
    // R10: mode change flushes without reset
    run_seg("R10 lead-in hdb3", 1, 0, 0, 60, 1, 0);
    run_seg("R10 after switch to b3zs", 0, 1, 0, 120, 1, 2);
    run_seg("R10 after switch to hdb3", 0, 0, 0, 120, 0, 2);
    // R6: bypass with arbitrary rail pairs
    run_seg("R6 bypass", 1, 1, 1, 100, 0, 0);
    // R7: all-ones, with or without bypass
    run_seg("R7 all ones", 1, 1, 2, 50, 0, 2);
    run_seg("R7 all ones", 1, 0, 2, 50, 0, 2);
    // R8: loopback wins over all-ones
    run_seg("R8 loopback", 1, 1, 3, 100, 0, 0);
    run_seg("R8 loopback", 1, 0, 3, 100, 0, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule